// File: doc/BRIEF.md
# Pseudo-SRAM Host Controller

This block sits between a simple synchronous host and a 32K x 8 pseudo-static RAM. The host offers one byte access at a time on a valid/ready request carrying a 15-bit address, a write flag and write data. The controller turns each accepted request into one memory cycle on the chip-select, write-strobe, address and split data lines. A read returns its byte on a one-cycle response strobe.

The memory's cells are dynamic, so the controller also keeps them alive. A free-running interval timer raises a refresh request at a fixed rate. The whole array needs 256 refreshes every 4 ms, which gives a default interval of 15.6 us. Each refresh is a low pulse on the shared read-enable/refresh line while chip select stays high. A pending refresh is served before the next host request but never cuts short an access already under way. After reset, both strobes are held inactive for a programmable start-up time of 1 ms by default, and no request is taken during that time. Every timing limit is a parameter counted in clock cycles.

Top module: `psram_ctrl`

## Requirements
- R1: From reset until INIT_CYC cycles have passed, chip select and the read/refresh line stay high, the write strobe stays high, the data bus is not driven and req_ready_o is low; after that time req_ready_o rises.
- R2: An accepted request pulls chip select low in the next cycle with the request's address on mem_addr_o, and chip select stays low for exactly CE_LOW_CYC cycles.
- R3: A read drives the read/refresh line low together with chip select. The byte on mem_dq_i in the last low cycle is returned on rsp_rdata_o, with rsp_valid_o high for one cycle, the cycle chip select rises. Writes produce no response.
- R4: A write holds the read/refresh line high and drives the write data for the whole chip-select window. The write strobe goes low for exactly WP_CYC cycles starting with chip select and rises while chip select is still low and the data is still driven.
- R5: Between two chip-select low windows, chip select stays high for at least CE_PRE_CYC cycles.
- R6: A refresh is a low pulse of exactly RF_PULSE_CYC cycles on the read/refresh line while chip select is high.
- R7: After a refresh pulse ends, chip select stays high for at least RF_REC_CYC cycles.
- R8: Once the start-up time has passed, a refresh request is raised every REFI_CYC cycles. On an idle host the pulses are exactly REFI_CYC cycles apart.
- R9: req_ready_o is high only while no access or refresh is running and no refresh is pending, so every strobe is inactive whenever it is high. A pending refresh wins over a waiting request, and a steady request stream does not starve refresh.
- R10: The data bus is driven (mem_dq_oe_o high) only during a write's chip-select window, and never while the read/refresh line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_addr_i | input | 15 | Byte address |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 8 | Write data |
| rsp_valid_o | output | 1 | Read data valid strobe |
| rsp_rdata_o | output | 8 | Read data |
| mem_cs_n_o | output | 1 | Memory chip select, active low |
| mem_rd_ref_n_o | output | 1 | Read enable while selected, refresh strobe while deselected, active low |
| mem_wr_n_o | output | 1 | Write strobe, active low |
| mem_addr_o | output | 15 | Memory address |
| mem_dq_o | output | 8 | Data toward memory |
| mem_dq_oe_o | output | 1 | Data bus drive enable |
| mem_dq_i | input | 8 | Data from memory |

## Verification
Chip select falls one cycle after the accepting edge and rises CE_LOW_CYC cycles later. The read response appears in the cycle chip select rises, and a refresh pulse begins the cycle after a pending request is seen in idle. The bench samples every output at the falling clock edge and measures each strobe by run-length counters, so it compares widths and gaps in whole cycles instead of guessing absolute times. Expected addresses, write data and read bytes come from a scoreboard queue filled by the driver. The monitor pops that queue when chip select falls, when the write strobe rises and when the response strobe fires.

// File: rtl/psram_pkg.sv
package psram_pkg;
  typedef enum logic [2:0] {
    ST_INIT, ST_IDLE, ST_ACC, ST_PRE, ST_RF, ST_RFREC
  } psram_st_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/psram_divider.sv
module psram_divider #(
  parameter int unsigned PERIOD  = 16,
  parameter bit          ONESHOT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [W-1:0] cnt_q;
  logic         wrap;
  assign wrap = (cnt_q == W'(PERIOD - 1));

  generate
    if (ONESHOT) begin : g_once
      logic done_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q  <= '0;
          done_q <= 1'b0;
        end else if (en_i && !done_q) begin
          if (wrap) done_q <= 1'b1;
          else      cnt_q  <= cnt_q + 1'b1;
        end
      end
      assign tick_o = done_q;
    end else begin : g_loop
      logic tick_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q  <= '0;
          tick_q <= 1'b0;
        end else begin
          tick_q <= en_i && wrap;
          if (en_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
      end
      assign tick_o = tick_q;
    end
  endgenerate
endmodule

// File: rtl/psram_seq.sv
module psram_seq
  import psram_pkg::*;
#(
  parameter int unsigned CE_LOW_CYC   = 4,
  parameter int unsigned CE_PRE_CYC   = 2,
  parameter int unsigned WP_CYC       = 3,
  parameter int unsigned RF_PULSE_CYC = 4,
  parameter int unsigned RF_REC_CYC   = 7
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      init_done_i,
  input  logic      rf_pend_i,
  input  logic      req_valid_i,
  output psram_st_e st_o,
  output logic      last_o,
  output logic      wp_o,
  output logic      ready_o,
  output logic      accept_o,
  output logic      rf_ack_o
);
  localparam int unsigned MAXC = max2(max2(CE_LOW_CYC, CE_PRE_CYC),
                                      max2(RF_PULSE_CYC, max2(RF_REC_CYC, WP_CYC)));
  localparam int unsigned CW   = $clog2(MAXC + 1);

  psram_st_e       st_q, st_d;
  logic [CW-1:0]   cnt_q, lim;
  logic            last;

  always_comb begin
    unique case (st_q)
      ST_ACC:   lim = CW'(CE_LOW_CYC - 1);
      ST_PRE:   lim = CW'(CE_PRE_CYC - 1);
      ST_RF:    lim = CW'(RF_PULSE_CYC - 1);
      ST_RFREC: lim = CW'(RF_REC_CYC - 1);
      default:  lim = '0;
    endcase
  end

  assign last = (cnt_q == lim);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_INIT:  if (init_done_i) st_d = ST_IDLE;
      ST_IDLE:  if (rf_pend_i) st_d = ST_RF;
                else if (req_valid_i) st_d = ST_ACC;
      ST_ACC:   if (last) st_d = ST_PRE;
      ST_PRE:   if (last) st_d = ST_IDLE;
      ST_RF:    if (last) st_d = ST_RFREC;
      ST_RFREC: if (last) st_d = ST_IDLE;
      default:  st_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_INIT;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_d != st_q) cnt_q <= '0;
      else if (!last)   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign st_o     = st_q;
  assign last_o   = last;
  assign wp_o     = (cnt_q < CW'(WP_CYC));
  assign ready_o  = (st_q == ST_IDLE) && !rf_pend_i;
  assign accept_o = ready_o && req_valid_i;
  assign rf_ack_o = (st_q == ST_IDLE) && rf_pend_i;
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_pkg::*;
#(
  parameter int unsigned AW           = 15,
  parameter int unsigned DW           = 8,
  parameter int unsigned INIT_CYC     = 50000,
  parameter int unsigned REFI_CYC     = 780,
  parameter int unsigned CE_LOW_CYC   = 4,
  parameter int unsigned CE_PRE_CYC   = 2,
  parameter int unsigned WP_CYC       = 3,
  parameter int unsigned RF_PULSE_CYC = 4,
  parameter int unsigned RF_REC_CYC   = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic          req_we_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          mem_cs_n_o,
  output logic          mem_rd_ref_n_o,
  output logic          mem_wr_n_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);
  logic      init_done, rf_tick, rf_pend_q, rf_ack;
  logic      accept, last, wp;
  psram_st_e st;

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          we_q, rsp_q;

  psram_divider #(.PERIOD(INIT_CYC), .ONESHOT(1'b1)) u_init (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(1'b1), .tick_o(init_done)
  );

  psram_divider #(.PERIOD(REFI_CYC), .ONESHOT(1'b0)) u_refi (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(init_done), .tick_o(rf_tick)
  );

  // a tick landing on the ack cycle stays pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rf_pend_q <= 1'b0;
    else         rf_pend_q <= rf_tick || (rf_pend_q && !rf_ack);
  end

  psram_seq #(
    .CE_LOW_CYC  (CE_LOW_CYC),
    .CE_PRE_CYC  (CE_PRE_CYC),
    .WP_CYC      (WP_CYC),
    .RF_PULSE_CYC(RF_PULSE_CYC),
    .RF_REC_CYC  (RF_REC_CYC)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_done_i(init_done),
    .rf_pend_i  (rf_pend_q),
    .req_valid_i(req_valid_i),
    .st_o       (st),
    .last_o     (last),
    .wp_o       (wp),
    .ready_o    (req_ready_o),
    .accept_o   (accept),
    .rf_ack_o   (rf_ack)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
      we_q    <= req_we_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      rsp_q <= (st == ST_ACC) && !we_q && last;
      if ((st == ST_ACC) && !we_q && last) rdata_q <= mem_dq_i;
    end
  end

  assign rsp_valid_o    = rsp_q;
  assign rsp_rdata_o    = rdata_q;
  assign mem_cs_n_o     = (st != ST_ACC);
  assign mem_rd_ref_n_o = !(((st == ST_ACC) && !we_q) || (st == ST_RF));
  assign mem_wr_n_o     = !((st == ST_ACC) && we_q && wp);
  assign mem_addr_o     = addr_q;
  assign mem_dq_o       = wdata_q;
  assign mem_dq_oe_o    = (st == ST_ACC) && we_q;
endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk #(
  parameter int unsigned CE_PRE_CYC   = 2,
  parameter int unsigned RF_PULSE_CYC = 4,
  parameter int unsigned RF_REC_CYC   = 7
) (
  input logic clk_i,
  input logic rst_ni,
  input logic init_done_i,
  input logic req_ready_o,
  input logic rsp_valid_o,
  input logic mem_cs_n_o,
  input logic mem_rd_ref_n_o,
  input logic mem_wr_n_o,
  input logic mem_dq_oe_o
);
  localparam int unsigned W = $clog2(CE_PRE_CYC + RF_PULSE_CYC + RF_REC_CYC + 2);

  logic [W-1:0] hi_cnt, rec_cnt, rf_run;
  logic         cs_n_q, rf_now;
  assign rf_now = mem_cs_n_o && !mem_rd_ref_n_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt  <= W'(CE_PRE_CYC);
      rec_cnt <= W'(RF_REC_CYC);
      rf_run  <= '0;
      cs_n_q  <= 1'b1;
    end else begin
      cs_n_q <= mem_cs_n_o;
      if (!mem_cs_n_o)                  hi_cnt <= '0;
      else if (hi_cnt < W'(CE_PRE_CYC)) hi_cnt <= hi_cnt + 1'b1;
      if (rf_now)                        rec_cnt <= '0;
      else if (rec_cnt < W'(RF_REC_CYC)) rec_cnt <= rec_cnt + 1'b1;
      if (rf_now && rf_run <= W'(RF_PULSE_CYC)) rf_run <= rf_run + 1'b1;
      else if (!rf_now)                         rf_run <= '0;
    end
  end

  a_r1_init_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_i |-> (mem_cs_n_o && mem_rd_ref_n_o && !req_ready_o));

  a_r3_rsp_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(!mem_cs_n_o && !mem_rd_ref_n_o));

  a_r4_wr_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_wr_n_o |-> (!mem_cs_n_o && mem_dq_oe_o && mem_rd_ref_n_o));

  a_r5_cs_precharge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_cs_n_o && cs_n_q) |-> (hi_cnt >= W'(CE_PRE_CYC)));

  a_r6_rf_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rf_now && rf_run != '0) |-> (rf_run == W'(RF_PULSE_CYC)));

  a_r7_rf_recovery: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_cs_n_o && cs_n_q) |-> (rec_cnt >= W'(RF_REC_CYC)));

  a_r9_ready_bus_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_cs_n_o && mem_rd_ref_n_o && mem_wr_n_o));

  a_r10_dq_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> (!mem_cs_n_o && mem_rd_ref_n_o));
endmodule

bind psram_ctrl psram_ctrl_chk #(
  .CE_PRE_CYC  (CE_PRE_CYC),
  .RF_PULSE_CYC(RF_PULSE_CYC),
  .RF_REC_CYC  (RF_REC_CYC)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .init_done_i   (init_done),
  .req_ready_o   (req_ready_o),
  .rsp_valid_o   (rsp_valid_o),
  .mem_cs_n_o    (mem_cs_n_o),
  .mem_rd_ref_n_o(mem_rd_ref_n_o),
  .mem_wr_n_o    (mem_wr_n_o),
  .mem_dq_oe_o   (mem_dq_oe_o)
);

// File: tb/psram_ctrl_tb_top.sv
module psram_ctrl_tb_top;
  localparam int INIT = 40;
  localparam int REFI = 150;
  localparam int CEL  = 4;
  localparam int CEP  = 2;
  localparam int WP   = 3;
  localparam int RFP  = 4;
  localparam int RFR  = 7;

  typedef struct packed {logic we; logic [14:0] a; logic [7:0] d;} op_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid, cs_n, rr_n, wr_n, dq_oe;
  logic [7:0]  rsp_rdata, dq_o;
  logic [14:0] mem_addr;
  logic [7:0]  dq_drv = 8'h3C;

  always #10 clk = ~clk;

  psram_ctrl #(
    .INIT_CYC(INIT), .REFI_CYC(REFI), .CE_LOW_CYC(CEL), .CE_PRE_CYC(CEP),
    .WP_CYC(WP), .RF_PULSE_CYC(RFP), .RF_REC_CYC(RFR)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_we_i(req_we), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .mem_cs_n_o(cs_n),
    .mem_rd_ref_n_o(rr_n), .mem_wr_n_o(wr_n), .mem_addr_o(mem_addr),
    .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_drv)
  );

  int n_chk = 0, n_fail = 0;
  op_t         acc_q[$];
  logic [7:0]  rd_q[$];
  logic [7:0]  exp_mem[int];
  logic [7:0]  mem_m[int];

  function automatic logic [7:0] fill(input logic [14:0] a);
    return a[7:0] ^ 8'hA5 ^ {1'b0, a[14:8]};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  // driver: push expectations, then hand the request over
  task automatic access(input bit we, input logic [14:0] a, input logic [7:0] d);
    acc_q.push_back('{we, a, d});
    if (we) exp_mem[a] = d;
    else    rd_q.push_back(exp_mem.exists(a) ? exp_mem[a] : fill(a));
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor / memory model
  op_t         cur = '0;
  logic [14:0] lat = '0;
  logic        pcs_n = 1'b1, pwr_n = 1'b1, prf = 1'b0, bad_dir = 1'b0;
  int ce_lo = 0, ce_hi = 0, wr_lo = 0, rf_lo = 0, since_rf = 1000;
  int rf_cnt = 0, cyc = 0, last_rf_end = -1, rf_gap = 0;
  int ready_viol = 0, cont_viol = 0;

  always @(negedge clk) begin
    logic rf_now;
    cyc++;
    rf_now = cs_n && !rr_n;
    if (rst_n) begin
      if (!cs_n && pcs_n) begin
        check(ce_hi >= CEP, "R5 cs high gap", ce_hi, CEP);
        check(since_rf >= RFR, "R7 refresh recovery", since_rf, RFR);
        if (acc_q.size() == 0) check(1'b0, "R2 unexpected access", 1, 0);
        else begin
          cur = acc_q.pop_front();
          check(mem_addr == cur.a, "R2 address", int'(mem_addr), int'(cur.a));
        end
        lat = mem_addr;
        bad_dir = 1'b0;
      end
      if (!cs_n && (cur.we ? (!dq_oe || !rr_n) : (dq_oe || rr_n))) bad_dir = 1'b1;
      if (cs_n && !pcs_n) begin
        check(ce_lo == CEL, "R2 cs low width", ce_lo, CEL);
        check(!bad_dir, "R10 bus direction in window", int'(bad_dir), 0);
      end
      if (wr_n && !pwr_n) begin
        check(wr_lo == WP, "R4 write strobe width", wr_lo, WP);
        check(!cs_n && dq_oe && dq_o == cur.d, "R4 write data held", int'(dq_o), int'(cur.d));
        mem_m[lat] = dq_o;
      end
      if (!rf_now && prf) begin
        check(rf_lo == RFP, "R6 refresh pulse width", rf_lo, RFP);
        rf_cnt++;
        if (last_rf_end >= 0) rf_gap = cyc - last_rf_end;
        last_rf_end = cyc;
      end
      if (req_ready && !(cs_n && rr_n && wr_n)) ready_viol++;
      if (dq_oe && !rr_n) cont_viol++;
      if (rsp_valid) begin
        if (rd_q.size() == 0) check(1'b0, "R3 response without read", 1, 0);
        else begin
          logic [7:0] e;
          e = rd_q.pop_front();
          check(rsp_rdata == e, "R3 read data", int'(rsp_rdata), int'(e));
        end
      end
      ce_lo    = !cs_n ? ce_lo + 1 : 0;
      ce_hi    = cs_n ? ce_hi + 1 : 0;
      wr_lo    = !wr_n ? wr_lo + 1 : 0;
      rf_lo    = rf_now ? rf_lo + 1 : 0;
      since_rf = rf_now ? 0 : since_rf + 1;
    end
    pcs_n = cs_n; pwr_n = wr_n; prf = rf_now;
    if (!cs_n && !rr_n) dq_drv <= mem_m.exists(lat) ? mem_m[lat] : fill(lat);
    else                dq_drv <= 8'h3C;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int bad, r0, c0;
    bit seen;
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    check(cs_n && rr_n && wr_n && !dq_oe && !req_ready && !rsp_valid,
          "R1 reset state", int'({cs_n, rr_n, wr_n, dq_oe, req_ready}), 5'b11100);
    rst_n = 1'b1;
    bad = 0;
    for (int i = 0; i < INIT - 2; i++) begin
      @(negedge clk);
      if (req_ready || !cs_n || !rr_n || !wr_n) bad++;
    end
    check(bad == 0, "R1 quiet during start-up", bad, 0);
    seen = 1'b0;
    for (int i = 0; i < 10 && !seen; i++) begin
      @(negedge clk);
      seen = req_ready;
    end
    check(seen, "R1 ready after start-up", int'(seen), 1);

    // idle refresh rate
    r0 = rf_cnt;
    repeat (10 * REFI) @(negedge clk);
    check((rf_cnt - r0) >= 9 && (rf_cnt - r0) <= 11, "R8 refresh count", rf_cnt - r0, 10);
    check(rf_gap == REFI, "R8 idle refresh spacing", rf_gap, REFI);

    // directed accesses, address corners
    access(1'b1, 15'h0000, 8'h11);
    access(1'b1, 15'h7FFF, 8'hFF);
    access(1'b1, 15'h1234, 8'h00);
    access(1'b0, 15'h0000, 8'h00);
    access(1'b0, 15'h7FFF, 8'h00);
    access(1'b0, 15'h1234, 8'h00);
    access(1'b0, 15'h4000, 8'h00);
    access(1'b1, 15'h1234, 8'h5A);
    access(1'b1, 15'h1234, 8'hC3);
    access(1'b0, 15'h1234, 8'h00);

    // streaming mix: refresh must still be served (R9)
    lf = 16'hACE1;
    r0 = rf_cnt;
    c0 = cyc;
    for (int i = 0; i < 80; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      access(lf[0], {11'h7F0, lf[4:1]}, lf[15:8]);
    end
    check((rf_cnt - r0) >= ((cyc - c0) / REFI) - 1 && (rf_cnt - r0) > 0,
          "R9 refresh not starved", rf_cnt - r0, (cyc - c0) / REFI);

    repeat (40) @(negedge clk);
    check(rd_q.size() == 0, "R3 all reads answered", rd_q.size(), 0);
    check(acc_q.size() == 0, "R2 all accesses issued", acc_q.size(), 0);
    check(ready_viol == 0, "R9 ready only with idle bus", ready_viol, 0);
    check(cont_viol == 0, "R10 no drive during read/refresh", cont_viol, 0);
    finish_run();
  end
endmodule